// File: doc/BRIEF.md
# Single-Check-Byte Error-Correcting Codec with Byte Fault Signalling

This block protects a 32-bit data word with one 8-bit check byte, so that the stored word is 40 bits wide. Those 40 bits are laid out as five 8-bit lanes, and each lane can sit in its own memory device. The block is purely combinational. An encoder path turns write data into the check byte. A decoder path takes a 40-bit read word and returns data, a corrected flag and an uncorrectable flag.

Every column of the parity-check matrix has odd weight, and the eight columns of any lane are linearly independent. Because of this, any single flipped bit is repaired, and any error that flips an even number of bits is rejected. A lane whose bits all read as zero or all read as one, after a device failure, is never reported as clean. Before it is stored, the check byte is XORed with a fixed nonzero mask of even weight. This keeps a word of all zeros and a word of all ones out of the code, so a dead bus or a floating bus is caught.

Top module: `ubyteSecCodec`

## Requirements
- R1: The stored word places data in bits 31:0 and the check byte in bits 39:32. Lane k covers bits 8k+7 down to 8k, and lane 4 is the check byte. Decoding the encoder's own output gives back the data with both flags low.
- R2: Flipping any one of the 40 stored bits produces the original data with the corrected flag high and the uncorrectable flag low. This holds when the flipped bit is a check bit too.
- R3: Flipping any two distinct stored bits raises the uncorrectable flag and leaves the corrected flag low.
- R4: Suppose one lane is forced to 0x00 or to 0xFF, and this changes an even, nonzero number of that lane's bits. The uncorrectable flag is then raised.
- R5: Suppose one lane is forced to 0x00 or to 0xFF. If no bit changes, the result is reported clean. If exactly one bit changes, the original data is returned with the corrected flag high. If any bits change, at least one flag is high.
- R6: A read word of all zeros raises the uncorrectable flag.
- R7: A read word of all ones raises the uncorrectable flag.
- R8: For every read word, exactly one outcome holds: clean, corrected or uncorrectable. At most one of the two flags is high.
- R9: While the uncorrectable flag is high, the output data equals bits 31:0 of the read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| encData | input | 32 | Data to be protected |
| encCheck | output | 8 | Masked check byte to store in bits 39:32 |
| decWord | input | 40 | Stored word as read back |
| decData | output | 32 | Repaired data, or raw data when rejected |
| decCorrected | output | 1 | One bit was repaired |
| decUncorrectable | output | 1 | Error that cannot be repaired |

## Verification
The block holds no state, so a bad internal value cannot hide. A wrong matrix column, a wrong mask bit or a stuck comparator shows at the ports in the same evaluation. It appears as a wrong check byte for some data pattern, or as a flipped data bit or a wrong flag for the single-bit, double-bit and forced-lane read words. The directed sweeps cover every bit position and every lane for both stuck values. As a result, each column and each mask bit appears in at least one comparison of outputs against values worked out from the requirements.

// File: rtl/ubCodecPkg.sv
package ubCodecPkg;

  localparam int BYTE_W     = 8;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = BYTE_W * DATA_BYTES;
  localparam int CHECK_W    = BYTE_W;
  localparam int WORD_W     = DATA_W + CHECK_W;

  // even weight, nonzero, not all ones: keeps the constant words out of the code
  localparam logic [CHECK_W-1:0] CHECK_MASK = 8'h3C;

  // strobes from the decision logic to the data path
  typedef struct packed {
    logic [DATA_W-1:0] flipData;
    logic              passClean;
    logic              fixOne;
    logic              reject;
  } corrStrobe_t;

  function automatic logic [BYTE_W-1:0] rotLeft(input logic [BYTE_W-1:0] v, input int n);
    logic [BYTE_W-1:0] t;
    t = v;
    for (int k = 0; k < n; k++) t = {t[BYTE_W-2:0], t[BYTE_W-1]};
    return t;
  endfunction

  // odd-weight seeds from distinct rotation classes; the circulant of each
  // is invertible, so each lane's eight columns are independent
  function automatic logic [BYTE_W-1:0] laneSeed(input int lane);
    case (lane % 4)
      0:       return 8'h07;
      1:       return 8'h0B;
      2:       return 8'h13;
      default: return 8'h25;
    endcase
  endfunction

  function automatic logic [CHECK_W-1:0] columnOf(input int idx);
    logic [CHECK_W-1:0] c;
    if (idx < DATA_W) c = rotLeft(laneSeed(idx / BYTE_W), idx % BYTE_W);
    else              c = CHECK_W'(1) << (idx - DATA_W);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] rowMask(input int row);
    logic [WORD_W-1:0] m;
    logic [CHECK_W-1:0] c;
    m = '0;
    for (int idx = 0; idx < WORD_W; idx++) begin
      c = columnOf(idx);
      m[idx] = c[row];
    end
    return m;
  endfunction

endpackage

// File: rtl/ubParityTree.sv
module ubParityTree
  import ubCodecPkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic [CHECK_W-1:0] parity
);

  for (genvar r = 0; r < CHECK_W; r++) begin : g_row
    localparam logic [WORD_W-1:0] ROW_SEL = rowMask(r);
    assign parity[r] = ^(word & ROW_SEL);
  end

endmodule

// File: rtl/ubDecodeCtl.sv
module ubDecodeCtl
  import ubCodecPkg::*;
(
  input  logic [CHECK_W-1:0] syndrome,
  output corrStrobe_t        strobe
);

  logic [WORD_W-1:0] colHit;

  for (genvar j = 0; j < WORD_W; j++) begin : g_cmp
    localparam logic [CHECK_W-1:0] COL_J = columnOf(j);
    assign colHit[j] = (syndrome == COL_J);
  end

  always_comb begin
    strobe.passClean = (syndrome == '0);
    strobe.fixOne    = |colHit;
    strobe.reject    = !strobe.passClean && !strobe.fixOne;
    strobe.flipData  = colHit[DATA_W-1:0];
  end

  always_comb begin
    // R8: a syndrome names at most one bit position
    p_single_target_r8: assert ($onehot0(colHit))
      else $error("more than one column matched");
    // R8: exactly one outcome is chosen
    p_one_outcome_r8: assert ($countones({strobe.passClean, strobe.fixOne, strobe.reject}) == 1)
      else $error("outcome strobes not exclusive");
  end

endmodule

// File: rtl/ubCorrectPath.sv
module ubCorrectPath
  import ubCodecPkg::*;
(
  input  logic [DATA_W-1:0] rawData,
  input  corrStrobe_t       strobe,
  output logic [DATA_W-1:0] outData
);

  always_comb begin
    outData = rawData ^ (strobe.fixOne ? strobe.flipData : '0);
  end

  always_comb begin
    // R9: rejected words pass through untouched
    if (strobe.reject)
      p_reject_passthru_r9: assert (outData == rawData)
        else $error("data altered on reject");
    // R2: a repair changes at most one data bit
    p_repair_one_bit_r2: assert ($countones(outData ^ rawData) <= 1)
      else $error("repair touched several bits");
  end

endmodule

// File: rtl/ubyteSecCodec.sv
module ubyteSecCodec
  import ubCodecPkg::*;
(
  input  logic [31:0] encData,
  output logic [7:0]  encCheck,
  input  logic [39:0] decWord,
  output logic [31:0] decData,
  output logic        decCorrected,
  output logic        decUncorrectable
);

  logic [CHECK_W-1:0] encParity;
  logic [CHECK_W-1:0] decParity;
  logic [CHECK_W-1:0] syndrome;
  corrStrobe_t        strobe;

  ubParityTree u_encTree (
    .word   ({{CHECK_W{1'b0}}, encData}),
    .parity (encParity)
  );

  ubParityTree u_decTree (
    .word   (decWord),
    .parity (decParity)
  );

  assign encCheck = encParity ^ CHECK_MASK;
  assign syndrome = decParity ^ CHECK_MASK;

  ubDecodeCtl u_ctl (
    .syndrome (syndrome),
    .strobe   (strobe)
  );

  ubCorrectPath u_path (
    .rawData (decWord[DATA_W-1:0]),
    .strobe  (strobe),
    .outData (decData)
  );

  assign decCorrected     = strobe.fixOne;
  assign decUncorrectable = strobe.reject;

  always_comb begin
    // R6: the all-zero word is rejected
    if (decWord == '0)
      p_zero_word_r6: assert (decUncorrectable)
        else $error("all-zero word accepted");
    // R7: the all-one word is rejected
    if (decWord == '1)
      p_ones_word_r7: assert (decUncorrectable)
        else $error("all-one word accepted");
  end

endmodule

// File: tb/tb_ubyteSecCodec.sv
module tb_ubyteSecCodec;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] encData = '0;
  logic [7:0]  encCheck;
  logic [39:0] decWord = '0;
  logic [31:0] decData;
  logic        decCorrected;
  logic        decUncorrectable;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  ubyteSecCodec dut (
    .encData          (encData),
    .encCheck         (encCheck),
    .decWord          (decWord),
    .decData          (decData),
    .decCorrected     (decCorrected),
    .decUncorrectable (decUncorrectable)
  );

  // act/exp are packed as {corrected, uncorrectable, data}
  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic encodeWord(input logic [31:0] d, output logic [39:0] w);
    @(negedge clk);
    encData = d;
    #2;
    w = {encCheck, d};
  endtask

  task automatic decodeWord(input logic [39:0] w);
    @(negedge clk);
    decWord = w;
    #2;
  endtask

  function automatic logic [33:0] outVec();
    return {decCorrected, decUncorrectable, decData};
  endfunction

  task automatic tIdle();
    logic [39:0] w;
    encodeWord(32'h0, w);
    chk(w != '0, "R6 zero data stored nonzero", {2'b00, w[39:8]}, 34'h1);
    decodeWord(w);
    chk(outVec() == {2'b00, 32'h0}, "R1 zero data clean", outVec(), {2'b00, 32'h0});
  endtask

  task automatic tCleanPatterns();
    logic [39:0] w;
    logic [31:0] d;
    for (int n = 0; n < 12; n++) begin
      case (n)
        0: d = 32'hFFFF_FFFF;
        1: d = 32'hA5A5_5A5A;
        2: d = 32'h1234_5678;
        default: d = $urandom();
      endcase
      encodeWord(d, w);
      decodeWord(w);
      chk(outVec() == {2'b00, d}, "R1 R8 clean round trip", outVec(), {2'b00, d});
    end
  endtask

  task automatic tSingle();
    logic [39:0] w;
    logic [31:0] d;
    for (int n = 0; n < 3; n++) begin
      d = (n == 0) ? 32'h0 : (n == 1) ? 32'hFFFF_FFFF : $urandom();
      encodeWord(d, w);
      for (int b = 0; b < 40; b++) begin
        decodeWord(w ^ (40'h1 << b));
        chk(outVec() == {2'b10, d}, "R2 single bit repaired", outVec(), {2'b10, d});
      end
    end
  endtask

  task automatic tDouble();
    logic [39:0] w;
    logic [39:0] bad;
    logic [31:0] d;
    int i;
    int j;
    for (int n = 0; n < 200; n++) begin
      d = $urandom();
      i = $urandom_range(39, 0);
      j = $urandom_range(38, 0);
      if (j >= i) j = j + 1;
      encodeWord(d, w);
      bad = w ^ (40'h1 << i) ^ (40'h1 << j);
      decodeWord(bad);
      chk(outVec() == {2'b01, bad[31:0]}, "R3 R9 double bit rejected", outVec(), {2'b01, bad[31:0]});
    end
  endtask

  task automatic tLaneStuck();
    logic [39:0] w;
    logic [39:0] bad;
    logic [31:0] d;
    logic [7:0]  forced;
    int          moved;
    bit          ok;
    for (int lane = 0; lane < 5; lane++) begin
      for (int v = 0; v < 2; v++) begin
        forced = (v == 0) ? 8'h00 : 8'hFF;
        for (int n = 0; n < 24; n++) begin
          d = (n == 0) ? 32'h0 : (n == 1) ? 32'hFFFF_FFFF : $urandom();
          encodeWord(d, w);
          bad = w;
          bad[lane*8 +: 8] = forced;
          moved = $countones(bad[lane*8 +: 8] ^ w[lane*8 +: 8]);
          decodeWord(bad);
          if (moved == 0) begin
            chk(outVec() == {2'b00, d}, "R5 unchanged lane clean", outVec(), {2'b00, d});
          end else if (moved == 1) begin
            chk(outVec() == {2'b10, d}, "R5 one-bit lane fault repaired", outVec(), {2'b10, d});
          end else if (moved % 2 == 0) begin
            chk(outVec() == {2'b01, bad[31:0]}, "R4 even lane fault rejected", outVec(), {2'b01, bad[31:0]});
          end else begin
            ok = decCorrected | decUncorrectable;
            chk(ok, "R5 odd lane fault flagged", outVec(), {2'b11, d});
          end
        end
      end
    end
  endtask

  task automatic tConstWords();
    decodeWord(40'h00_0000_0000);
    chk(outVec() == {2'b01, 32'h0}, "R6 all-zero word rejected", outVec(), {2'b01, 32'h0});
    decodeWord(40'hFF_FFFF_FFFF);
    chk(outVec() == {2'b01, 32'hFFFF_FFFF}, "R7 all-one word rejected", outVec(), {2'b01, 32'hFFFF_FFFF});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    tIdle();
    tCleanPatterns();
    tSingle();
    tDouble();
    tLaneStuck();
    tConstWords();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule